// File: doc/BRIEF.md
# Selectable-Parent Two-Stage Clock Divider

This block derives one peripheral clock from one of several free-running parent clocks. A single 32-bit control word holds all the settings: a parent selector, a power-of-two prescale exponent P, a linear factor M and a run bit. The output period equals the selected parent period multiplied by (M+1)·2^P, so the output runs anywhere from the parent rate down to 1/128 of it. It never runs faster than the parent.

Software writes the control word through a simple write strobe in the register clock domain and reads it back unchanged apart from the reserved bits. The divider counters run on the selected parent clock. The settings reach them through a two-flop synchronizer and are adopted only where one output period ends and the next begins. This way a change of factors or of the run bit never produces a shortened pulse. A divide ratio of one passes the parent through a clock gate that is latched while the parent is low.

Top module: `clk_mod_div`

## Requirements
- R1: After reset the control word reads 0x0000_0000 and `clk_out` is low.
- R2: Control bits are retained at these positions: bit 31 run, bits 25:24 parent select, bits 17:16 exponent P, bits 3:0 factor M. Every other bit reads as zero whatever was written, so writing 0xFFFF_FFFF reads back 0x8303_000F.
- R3: With run set, the `clk_out` period equals the selected parent period times (M+1)·2^P. It is never shorter than one parent period.
- R4: For a total ratio D = (M+1)·2^P of two or more, `clk_out` is high for floor(D/2) parent periods in each output period. For D = 1 it follows the parent waveform.
- R5: Select values 0 to NUM_PAR-1 (default 0..2) pick `par_clk` at that index. Any higher select value holds `clk_out` constantly low.
- R6: With the run bit clear, `clk_out` stays low and shows no rising edge.
- R7: New M or P values take effect only after the output period in progress completes. The period running when the write lands keeps its old length.
- R8: Clearing the run bit while `clk_out` is high does not cut that high phase short. It ends at its normal falling time, and no later rising edge follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word, reserved bits zero |
| par_clk | input | NUM_PAR | Parent clock inputs |
| clk_out | output | 1 | Divided, gated output clock |

## Verification
The bench measures real edge times of `clk_out` against each parent period. A prescaler or linear counter that is off by one shows up as a wrong period or high time, and so does a wrong duty split for odd ratios. Factor updates are written just after an output rising edge: a design that adopts them at once would shorten the running 128-cycle period instead of finishing it. Clearing the run bit in the middle of a high phase checks for runt pulses, which an immediate gate would produce as an early fall. The unused select value and the all-ones readback catch a mux that indexes past its inputs and reserved bits that hold stored data.

// File: rtl/clk_mod_div.sv
module clk_mod_div #(
  parameter int NUM_PAR = 3,
  parameter int MW      = 4,
  parameter int PW      = 2,
  parameter int SW      = 2,
  parameter int EN_BIT  = 31,
  parameter int SEL_LSB = 24,
  parameter int P_LSB   = 16,
  parameter int M_LSB   = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  input  logic [NUM_PAR-1:0] par_clk,
  output logic               clk_out
);
  localparam int PADN = 1 << SW;
  localparam int PCW  = (1 << PW) - 1;
  localparam int POSW = MW + PCW;
  localparam int DW   = MW + PCW + 1;
  localparam int CW   = 1 + PW + MW;
  localparam logic [31:0] MASK = (32'd1 << EN_BIT)
                               | (32'((1 << SW) - 1) << SEL_LSB)
                               | (32'((1 << PW) - 1) << P_LSB)
                               | (32'((1 << MW) - 1) << M_LSB);

  logic          en_r;
  logic [SW-1:0] sel_r;
  logic [PW-1:0] p_r;
  logic [MW-1:0] m_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r  <= 1'b0;
      sel_r <= '0;
      p_r   <= '0;
      m_r   <= '0;
    end else if (wr_en) begin
      en_r  <= wr_data[EN_BIT];
      sel_r <= wr_data[SEL_LSB +: SW];
      p_r   <= wr_data[P_LSB +: PW];
      m_r   <= wr_data[M_LSB +: MW];
    end
  end

  always_comb begin
    rd_data                 = '0;
    rd_data[EN_BIT]         = en_r;
    rd_data[SEL_LSB +: SW]  = sel_r;
    rd_data[P_LSB +: PW]    = p_r;
    rd_data[M_LSB +: MW]    = m_r;
  end

  logic [PADN-1:0] par_pad;
  logic            sel_clk;
  logic            sel_valid;
  assign par_pad   = PADN'(par_clk);
  assign sel_clk   = par_pad[sel_r];
  assign sel_valid = int'(sel_r) < NUM_PAR;

  logic [CW-1:0] cfg_s1, cfg_s2;
  always_ff @(posedge sel_clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_s1 <= '0;
      cfg_s2 <= '0;
    end else begin
      cfg_s1 <= {en_r, p_r, m_r};
      cfg_s2 <= cfg_s1;
    end
  end

  logic          s_en;
  logic [PW-1:0] s_p;
  logic [MW-1:0] s_m;
  assign s_en = cfg_s2[CW-1];
  assign s_p  = cfg_s2[MW +: PW];
  assign s_m  = cfg_s2[MW-1:0];

  logic           a_en;
  logic [PW-1:0]  a_p;
  logic [MW-1:0]  a_m;
  logic [PCW-1:0] pcnt, pcnt_n, pmax;
  logic [MW-1:0]  mcnt, mcnt_n;
  logic [POSW-1:0] pos_n;
  logic [DW-1:0]  dval_a, half_a;
  logic           byp_a, byp_s, at_end;
  logic           div_q, byp_g;

  assign pmax   = PCW'((32'd1 << a_p) - 32'd1);
  assign at_end = (pcnt == pmax) && (mcnt == a_m);
  assign dval_a = (DW'(a_m) + DW'(1)) << a_p;
  assign half_a = dval_a >> 1;
  assign byp_a  = (a_m == '0) && (a_p == '0);
  assign byp_s  = (s_m == '0) && (s_p == '0);

  always_comb begin
    if (pcnt == pmax) begin
      pcnt_n = '0;
      mcnt_n = mcnt + MW'(1);
    end else begin
      pcnt_n = pcnt + PCW'(1);
      mcnt_n = mcnt;
    end
    pos_n = (POSW'(mcnt_n) << a_p) | POSW'(pcnt_n);
  end

  always_ff @(posedge sel_clk or negedge rst_n) begin
    if (!rst_n) begin
      a_en  <= 1'b0;
      a_p   <= '0;
      a_m   <= '0;
      pcnt  <= '0;
      mcnt  <= '0;
      div_q <= 1'b0;
    end else if (at_end) begin
      a_en  <= s_en;
      a_p   <= s_p;
      a_m   <= s_m;
      pcnt  <= '0;
      mcnt  <= '0;
      div_q <= s_en & ~byp_s;
    end else begin
      pcnt  <= pcnt_n;
      mcnt  <= mcnt_n;
      div_q <= a_en & ~byp_a & (DW'(pos_n) < half_a);
    end
  end

  always_ff @(negedge sel_clk or negedge rst_n) begin
    if (!rst_n) byp_g <= 1'b0;
    else        byp_g <= a_en & byp_a;
  end

  assign clk_out = sel_valid & (div_q | (sel_clk & byp_g));

  p_wr_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & MASK));
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));
  p_hold_r7: assert property (@(posedge sel_clk) disable iff (!rst_n)
    !at_end |=> ($stable(a_m) && $stable(a_p) && $stable(a_en)));
  p_cnt_range_r3: assert property (@(posedge sel_clk) disable iff (!rst_n)
    (mcnt <= a_m) && (pcnt <= pmax));
  p_gate_r6: assert property (@(posedge sel_clk) disable iff (!rst_n)
    (!a_en && !s_en) |=> !div_q);
  p_bypass_r4: assert property (@(posedge sel_clk) disable iff (!rst_n)
    (byp_a && byp_s) |=> !div_q);
endmodule

// File: tb/tb_clk_mod_div.sv
`timescale 1ns/1ps
module tb_clk_mod_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [2:0]  par_clk = '0;
  logic        clk_out;

  int checks = 0;
  int errors = 0;
  int rises = 0;
  bit done = 1'b0;

  real tpar [3] = '{7.0, 12.0, 20.0};

  clk_mod_div dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .par_clk(par_clk), .clk_out(clk_out)
  );

  always #2.5 clk = ~clk;
  always #3.5 par_clk[0] = ~par_clk[0];
  always #6.0 par_clk[1] = ~par_clk[1];
  always #10.0 par_clk[2] = ~par_clk[2];
  always @(posedge clk_out) rises++;

  function automatic logic [31:0] cfg(bit en, int sel, int p, int m);
    return {en, 5'd0, 2'(sel), 6'd0, 2'(p), 12'd0, 4'(m)};
  endfunction
  function automatic real exp_per(int m, int p, real tp);
    return tp * real'((m + 1) << p);
  endfunction
  function automatic real exp_hi(int m, int p, real tp);
    int d = (m + 1) << p;
    return (d == 1) ? tp / 2.0 : tp * real'(d / 2);
  endfunction

  task automatic chk_real(string tag, real act, real exp);
    checks++;
    if (act - exp > 0.01 || exp - act > 0.01) begin
      errors++;
      $display("FAIL %s: actual %0.3f expected %0.3f", tag, act, exp);
    end
  endtask
  task automatic chk_int(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask
  task automatic wr(logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask
  task automatic measure(output real per, output real hi);
    real t0, t1, t2;
    @(posedge clk_out); t0 = $realtime;
    @(negedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    per = t2 - t0;
    hi = t1 - t0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #900000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    real per, hi, t0, t1, t2;
    int n0;
    void'($urandom(32'd2024));
    #1;
    chk_int("R1 reset readback", rd_data, 0);
    chk_int("R1 reset output", clk_out, 0);
    #20 rst_n = 1'b1;
    #100;
    chk_int("R1 output idle after reset", clk_out, 0);

    wr(32'hFFFF_FFFF);
    #1 chk_int("R2 all-ones readback", rd_data, 32'h8303_000F);
    wr(32'h5A5A_5A5A);
    #1 chk_int("R2 pattern readback", rd_data, 32'h5A5A_5A5A & 32'h8303_000F);

    for (int i = 0; i < 12; i++) begin
      int m = $urandom % 16;
      int p = $urandom % 4;
      int s = $urandom % 3;
      if (i == 0) begin m = 0; p = 0; end
      if (i == 1) begin m = 15; p = 3; end
      if (i == 2) begin m = 2; p = 0; end
      wr(cfg(1'b1, s, p, m));
      #(300.0 * tpar[s]);
      measure(per, hi);
      chk_real($sformatf("R3 period m=%0d p=%0d sel=%0d", m, p, s), per, exp_per(m, p, tpar[s]));
      chk_real($sformatf("R4 high m=%0d p=%0d sel=%0d", m, p, s), hi, exp_hi(m, p, tpar[s]));
    end

    wr(cfg(1'b1, 1, 0, 0));
    #(300.0 * tpar[1]);
    measure(per, hi);
    chk_real("R5 select 1 passthrough", per, tpar[1]);
    wr(cfg(1'b1, 3, 0, 0));
    #50;
    n0 = rises;
    #2000;
    chk_int("R5 unused select edges", rises - n0, 0);
    chk_int("R5 unused select level", clk_out, 0);

    wr(cfg(1'b0, 0, 1, 2));
    #(300.0 * tpar[0]);
    n0 = rises;
    #3000;
    chk_int("R6 disabled edges", rises - n0, 0);
    chk_int("R6 disabled level", clk_out, 0);

    wr(cfg(1'b1, 2, 3, 15));
    #(300.0 * tpar[2]);
    @(posedge clk_out); t0 = $realtime;
    wr(cfg(1'b1, 2, 1, 0));
    @(posedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    chk_real("R7 running period kept", t1 - t0, 128.0 * tpar[2]);
    chk_real("R7 new period after boundary", t2 - t1, 2.0 * tpar[2]);

    wr(cfg(1'b1, 2, 3, 15));
    #(300.0 * tpar[2]);
    @(posedge clk_out); t0 = $realtime;
    #(10.0 * tpar[2]);
    wr(cfg(1'b0, 2, 3, 15));
    @(negedge clk_out); t1 = $realtime;
    chk_real("R8 high phase full length", t1 - t0, 64.0 * tpar[2]);
    n0 = rises;
    #(300.0 * tpar[2]);
    chk_int("R8 no rise after disable", rises - n0, 0);

    done = 1'b1;
    finish_run();
  end
endmodule